// File: doc/BRIEF.md
# Wormhole Packet Switch with Drop-and-Retry Flow Control

This block routes wormhole packets from several input links to several output links. A packet is a head flit, then any number of body flits, then a tail flit. The head carries a source route: its lowest two bits name the output port at this switch. When a head flit wins its output, that output stays reserved for the input until the packet's tail goes through. The switch shifts the route field before the head leaves, so the next switch finds its own port in the lowest two bits.

The switch never stalls an input. A flit that cannot be placed in its output queue is discarded and answered with a negative acknowledge. An accepted flit is answered with a positive acknowledge. After a discard, the rest of that packet is discarded as well, until the sender starts over with the header. Each output has a small FIFO that the downstream link drains. Competing head flits are resolved by fixed priority or by round robin, chosen by a parameter. A flit reaches an empty output queue's port two cycles after it is driven.

Top module: `wh_switch`

## Requirements
- R1: Flit kinds are encoded on 2 bits as 0 idle, 1 head, 2 body, 3 tail. A head flit whose output (data bits [1:0]) is free and whose queue has room is accepted. When its queue was empty, it appears on that output two clock edges after it is driven. On the way out, the route field (data bits [7:0]) is shifted right by 2 with zero fill, and the upper data bits are unchanged.
- R2: Body and tail flits of an accepted packet follow the head to the same output, unchanged and acknowledged. An accepted tail frees the output for any input.
- R3: A head flit aimed at an output that another input's packet holds is dropped and negatively acknowledged, and it is not forwarded.
- R4: A flit whose output queue holds Q_DEPTH entries is dropped and negatively acknowledged, even if an entry leaves in that same cycle. A body or tail flit dropped this way frees the packet's output.
- R5: Once a flit of a packet is dropped, every later body or tail flit on that input is dropped and negatively acknowledged, until a head flit is accepted there.
- R6: When several head flits ask for the same free output in one cycle, exactly one is accepted and the others are negatively acknowledged. With fixed priority, the lowest input index wins.
- R7: With round robin, each output starts at input 0 after reset. After a grant, its search starts at the input after the winner. Cycles without a grant leave the search start unchanged.
- R8: Each non-idle flit gets exactly one of ack or nack, in the same cycle that an accepted flit could first appear at an output. An idle input gets neither.
- R9: After reset, all outputs show idle, ack and nack are low, and no output is held.
- R10: An output queue keeps flit order. While out_ready is low, the head entry stays on the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_kind | input | 2*N_IN | Flit kind per input, input i at bits [2i+1:2i] |
| in_data | input | DATA_W*N_IN | Flit data per input |
| ack | output | N_IN | Flit accepted, one bit per input |
| nack | output | N_IN | Flit dropped, one bit per input |
| out_kind | output | 2*N_OUT | Kind of each output queue's front entry, idle when the queue is empty |
| out_data | output | DATA_W*N_OUT | Data of each output queue's front entry |
| out_ready | input | N_OUT | Downstream takes the front entry of that output |

## Verification
The assertions check the following on every cycle:
- Every accept or drop decision shows up one cycle later as ack or nack.
- No head flit passes an output held by another input.
- A body or tail flit with no reserved path is always dropped.
- An input never holds two outputs at once.
- A tail frees its output.
- No queue is written while full.

Some behaviours only the bench scenarios can show:
- The output latency.
- The shifted route values.
- Which input wins under each arbitration policy.
- The round-robin start after idle cycles.
- FIFO order and stall behaviour when a queue fills and then drains.

// File: rtl/wh_pkg.sv
package wh_pkg;
  typedef enum logic [1:0] {
    FK_IDLE = 2'd0,
    FK_HEAD = 2'd1,
    FK_BODY = 2'd2,
    FK_TAIL = 2'd3
  } fkind_e;

  // route bits consumed per hop
  localparam int HOP_W = 2;
endpackage

// File: rtl/wh_arb.sv
module wh_arb #(
  parameter int N  = 3,
  parameter bit RR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] base;
  logic [IW-1:0] win;
  logic          found;

  function automatic int rot(input int b, input int k);
    int r;
    r = b + k;
    if (r >= N) r = r - N;
    return r;
  endfunction

  if (RR) begin : g_rr
    assign base = ptr;
  end else begin : g_fix
    assign base = '0;
  end

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[rot(int'(base), k)]) begin
        gnt[rot(int'(base), k)] = 1'b1;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    win = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) win = IW'(i);
    end
  end

  // search start moves only when a grant is made
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (found) begin
      ptr <= (int'(win) == N - 1) ? '0 : win + IW'(1);
    end
  end
endmodule

// File: rtl/wh_outq.sv
module wh_outq #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/wh_switch.sv
module wh_switch
  import wh_pkg::*;
#(
  parameter int N_IN    = 3,
  parameter int N_OUT   = 4,
  parameter int DATA_W  = 16,
  parameter int ROUTE_W = 8,
  parameter int Q_DEPTH = 4,
  parameter bit ARB_RR  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*N_IN-1:0]       in_kind,
  input  logic [DATA_W*N_IN-1:0]  in_data,
  output logic [N_IN-1:0]         ack,
  output logic [N_IN-1:0]         nack,
  output logic [2*N_OUT-1:0]      out_kind,
  output logic [DATA_W*N_OUT-1:0] out_data,
  input  logic [N_OUT-1:0]        out_ready
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int OW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam int FW = 2 + DATA_W;

  // output port addressed by this hop
  function automatic logic [HOP_W-1:0] route_port(input logic [DATA_W-1:0] d);
    return d[HOP_W-1:0];
  endfunction

  // consume this hop's bits so the next switch sees its own port
  function automatic logic [DATA_W-1:0] route_shift(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    r[ROUTE_W-1:0] = d[ROUTE_W-1:0] >> HOP_W;
    return r;
  endfunction

  // input stage registers
  logic [1:0]        st_kind [N_IN];
  logic [DATA_W-1:0] st_data [N_IN];

  // per-input path state
  logic [N_IN-1:0]   path_act;
  logic [OW-1:0]     path_port [N_IN];

  // per-output reservation
  logic [N_OUT-1:0]  lock_vld;
  logic [IW-1:0]     lock_own [N_OUT];
  logic [N_OUT-1:0]  lock_vld_nx;
  logic [IW-1:0]     lock_own_nx [N_OUT];

  // decode and decision events
  logic [N_IN-1:0]   is_head, is_flow, is_tail;
  logic [HOP_W-1:0]  hd_port [N_IN];
  logic [N_IN-1:0]   ev_acc, ev_drop, ev_tail_done, rel_in;

  // arbitration and queues
  logic [N_IN-1:0]   req [N_OUT];
  logic [N_IN-1:0]   gnt [N_OUT];
  logic [N_OUT-1:0]  q_push, q_pop, q_empty, q_full;
  logic [FW-1:0]     q_wdata [N_OUT];
  logic [FW-1:0]     q_rdata [N_OUT];

  // flat views for the checker
  logic [2*N_IN-1:0]     st_kind_f;
  logic [HOP_W*N_IN-1:0] hd_port_f;
  logic [IW*N_OUT-1:0]   lock_own_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IN; i++) begin
        st_kind[i] <= 2'(FK_IDLE);
        st_data[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        st_kind[i] <= in_kind[2*i +: 2];
        st_data[i] <= in_data[DATA_W*i +: DATA_W];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      is_head[i] = (st_kind[i] == 2'(FK_HEAD));
      is_tail[i] = (st_kind[i] == 2'(FK_TAIL));
      is_flow[i] = (st_kind[i] == 2'(FK_BODY)) || is_tail[i];
      hd_port[i] = route_port(st_data[i]);
    end
  end

  // a head may compete only for a free (or self-held) output with room
  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      for (int i = 0; i < N_IN; i++) begin
        req[o][i] = is_head[i] && (int'(hd_port[i]) == o) && !q_full[o] &&
                    (!lock_vld[o] || (int'(lock_own[o]) == i));
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      ev_acc[i] = 1'b0;
      if (is_head[i]) begin
        for (int o = 0; o < N_OUT; o++) begin
          if (gnt[o][i]) ev_acc[i] = 1'b1;
        end
      end else if (is_flow[i]) begin
        ev_acc[i] = path_act[i] && !q_full[path_port[i]];
      end
      ev_drop[i]      = (st_kind[i] != 2'(FK_IDLE)) && !ev_acc[i];
      ev_tail_done[i] = is_tail[i] && ev_acc[i];
      rel_in[i]       = is_head[i] || (is_flow[i] && (ev_drop[i] || is_tail[i]));
    end
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      q_push[o]  = 1'b0;
      q_wdata[o] = '0;
      for (int i = 0; i < N_IN; i++) begin
        if (gnt[o][i]) begin
          q_push[o]  = 1'b1;
          q_wdata[o] = {2'(FK_HEAD), route_shift(st_data[i])};
        end else if (is_flow[i] && ev_acc[i] && (int'(path_port[i]) == o)) begin
          q_push[o]  = 1'b1;
          q_wdata[o] = {st_kind[i], st_data[i]};
        end
      end
    end
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      lock_vld_nx[o] = lock_vld[o];
      lock_own_nx[o] = lock_own[o];
      for (int i = 0; i < N_IN; i++) begin
        if (lock_vld[o] && (int'(lock_own[o]) == i) && rel_in[i]) lock_vld_nx[o] = 1'b0;
      end
      for (int i = 0; i < N_IN; i++) begin
        if (gnt[o][i]) begin
          lock_vld_nx[o] = 1'b1;
          lock_own_nx[o] = IW'(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack      <= '0;
      nack     <= '0;
      path_act <= '0;
      lock_vld <= '0;
      for (int i = 0; i < N_IN; i++) path_port[i] <= '0;
      for (int o = 0; o < N_OUT; o++) lock_own[o] <= '0;
    end else begin
      ack      <= ev_acc;
      nack     <= ev_drop;
      lock_vld <= lock_vld_nx;
      for (int o = 0; o < N_OUT; o++) lock_own[o] <= lock_own_nx[o];
      for (int i = 0; i < N_IN; i++) begin
        if (is_head[i]) begin
          path_act[i]  <= ev_acc[i];
          path_port[i] <= OW'(hd_port[i]);
        end else if (rel_in[i]) begin
          path_act[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    wh_arb #(.N(N_IN), .RR(ARB_RR)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req[o]),
      .gnt  (gnt[o])
    );
    wh_outq #(.W(FW), .DEPTH(Q_DEPTH)) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .push (q_push[o]),
      .wdata(q_wdata[o]),
      .pop  (q_pop[o]),
      .rdata(q_rdata[o]),
      .empty(q_empty[o]),
      .full (q_full[o])
    );
    assign q_pop[o] = out_ready[o] && !q_empty[o];
    assign out_kind[2*o +: 2] = q_empty[o] ? 2'(FK_IDLE) : q_rdata[o][FW-1 -: 2];
    assign out_data[DATA_W*o +: DATA_W] = q_empty[o] ? '0 : q_rdata[o][DATA_W-1:0];
    assign lock_own_f[IW*o +: IW] = lock_own[o];
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_flat
    assign st_kind_f[2*i +: 2]         = st_kind[i];
    assign hd_port_f[HOP_W*i +: HOP_W] = hd_port[i];
  end
endmodule

// File: rtl/wh_switch_chk.sv
module wh_switch_chk
  import wh_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int N_OUT = 4,
  parameter int IW    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2*N_IN-1:0]       st_kind_f,
  input logic [HOP_W*N_IN-1:0]   hd_port_f,
  input logic [N_IN-1:0]         path_act,
  input logic [N_IN-1:0]         ev_acc,
  input logic [N_IN-1:0]         ev_drop,
  input logic [N_IN-1:0]         ev_tail_done,
  input logic [N_IN-1:0]         ack,
  input logic [N_IN-1:0]         nack,
  input logic [N_OUT-1:0]        lock_vld,
  input logic [IW*N_OUT-1:0]     lock_own_f,
  input logic [N_OUT-1:0]        q_full,
  input logic [N_OUT-1:0]        q_push
);
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic [1:0]       k;
    logic [N_OUT-1:0] own_v;
    assign k = st_kind_f[2*i +: 2];
    for (genvar o = 0; o < N_OUT; o++) begin : g_own
      assign own_v[o] = lock_vld[o] && (lock_own_f[IW*o +: IW] == IW'(i));

      a_r3_held_head_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (k == 2'(FK_HEAD) && int'(hd_port_f[HOP_W*i +: HOP_W]) == o &&
         lock_vld[o] && lock_own_f[IW*o +: IW] != IW'(i)) |-> ev_drop[i]);
    end

    a_r8_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack[i] && nack[i]));

    a_r8_ack_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      ev_acc[i] |=> ack[i]);

    a_r8_nack_follows_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ev_drop[i] |=> nack[i]);

    a_r5_pathless_flit_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      ((k == 2'(FK_BODY) || k == 2'(FK_TAIL)) && !path_act[i]) |-> ev_drop[i]);

    a_r2_one_path_per_input: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(own_v) <= 1);

    a_r2_tail_frees_output: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tail_done[i] |=> (own_v == '0));
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_q
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      q_full[o] |-> !q_push[o]);
  end
endmodule

bind wh_switch wh_switch_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_kind_f   (st_kind_f),
  .hd_port_f   (hd_port_f),
  .path_act    (path_act),
  .ev_acc      (ev_acc),
  .ev_drop     (ev_drop),
  .ev_tail_done(ev_tail_done),
  .ack         (ack),
  .nack        (nack),
  .lock_vld    (lock_vld),
  .lock_own_f  (lock_own_f),
  .q_full      (q_full),
  .q_push      (q_push)
);

// File: tb/wh_switch_tb_top.sv
module wh_switch_tb_top;
  import wh_pkg::*;

  localparam int NI = 3;
  localparam int NO = 4;
  localparam int DW = 16;
  localparam int NV = 10;

  // {kind, data, expected port, expected output data}
  localparam logic [35:0] VEC [NV] = '{
    {2'd1, 16'hA51B, 2'd3, 16'hA506},
    {2'd2, 16'h1234, 2'd3, 16'h1234},
    {2'd3, 16'hBEEF, 2'd3, 16'hBEEF},
    {2'd1, 16'h00E4, 2'd0, 16'h0039},
    {2'd3, 16'h5555, 2'd0, 16'h5555},
    {2'd1, 16'h7F02, 2'd2, 16'h7F00},
    {2'd2, 16'hCAFE, 2'd2, 16'hCAFE},
    {2'd3, 16'h0001, 2'd2, 16'h0001},
    {2'd1, 16'h3CFD, 2'd1, 16'h3C3F},
    {2'd3, 16'hFFFF, 2'd1, 16'hFFFF}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2*NI-1:0] in_kind = '0;
  logic [DW*NI-1:0] in_data = '0;
  logic [NO-1:0]   out_ready = '1;
  logic [NI-1:0]   ack_i, nack_i, ack_f, nack_f;
  logic [2*NO-1:0] okind_i, okind_f;
  logic [DW*NO-1:0] odata_i, odata_f;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wh_switch #(.ARB_RR(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_kind(in_kind), .in_data(in_data),
    .ack(ack_i), .nack(nack_i), .out_kind(okind_i), .out_data(odata_i),
    .out_ready(out_ready)
  );

  wh_switch #(.ARB_RR(1'b0)) dut_fp (
    .clk(clk), .rst_n(rst_n), .in_kind(in_kind), .in_data(in_data),
    .ack(ack_f), .nack(nack_f), .out_kind(okind_f), .out_data(odata_f),
    .out_ready(out_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [1:0] k, input logic [DW-1:0] d);
    in_kind[2*i +: 2] = k;
    in_data[DW*i +: DW] = d;
  endtask

  task automatic idle_all();
    in_kind = '0;
    in_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_all();
    out_ready = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R9: reset state
    chk("R9 out_kind idle", 32'(okind_i), 32'h0);
    chk("R9 ack low", 32'(ack_i), 32'h0);
    chk("R9 nack low", 32'(nack_i), 32'h0);
    chk("R9 fixed out_kind idle", 32'(okind_f), 32'h0);

    // vector walk on input 0: R1 heads, R2 bodies/tails, R8 replies
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      put(0, VEC[v][35:34], VEC[v][33:18]);
      @(negedge clk);
      idle_all();
      @(negedge clk);
      chk($sformatf("%s vec%0d kind", (VEC[v][35:34] == 2'd1) ? "R1" : "R2", v),
          32'(okind_i[2*VEC[v][17:16] +: 2]), 32'(VEC[v][35:34]));
      chk($sformatf("%s vec%0d data", (VEC[v][35:34] == 2'd1) ? "R1" : "R2", v),
          32'(odata_i[DW*VEC[v][17:16] +: DW]), 32'(VEC[v][15:0]));
      chk($sformatf("R8 vec%0d ack", v), 32'(ack_i), 32'h1);
      chk($sformatf("R8 vec%0d nack", v), 32'(nack_i), 32'h0);
    end

    // held output, go-back-N, release on tail
    do_reset();
    @(negedge clk); put(0, 2'd1, 16'h0001);
    @(negedge clk); put(0, 2'd2, 16'hAAAA); put(1, 2'd1, 16'h0041);
    @(negedge clk);
    chk("R1 held-test head ack", 32'(ack_i[0]), 32'h1);
    chk("R1 held-test head data", 32'(odata_i[DW*1 +: DW]), 32'h0000);
    put(0, 2'd3, 16'hBBBB); put(1, 2'd2, 16'hCCCC);
    @(negedge clk);
    chk("R3 held head nack", 32'(nack_i[1]), 32'h1);
    chk("R3 dropped head not forwarded", 32'(odata_i[DW*1 +: DW]), 32'hAAAA);
    chk("R2 body ack", 32'(ack_i[0]), 32'h1);
    idle_all(); put(1, 2'd1, 16'h0045);
    @(negedge clk);
    chk("R5 body after drop nack", 32'(nack_i[1]), 32'h1);
    chk("R2 tail forwarded", 32'(okind_i[2*1 +: 2]), 32'h3);
    idle_all();
    @(negedge clk);
    chk("R2 head after release ack", 32'(ack_i[1]), 32'h1);
    chk("R2 head after release data", 32'(odata_i[DW*1 +: DW]), 32'h0011);
    put(1, 2'd3, 16'h7777);
    @(negedge clk); idle_all();
    @(negedge clk);
    chk("R2 second packet tail ack", 32'(ack_i[1]), 32'h1);
    chk("R8 idle input no reply", 32'({ack_i[2], nack_i[2], ack_i[0], nack_i[0]}), 32'h0);

    // queue full, drop releases path, FIFO order and stall
    do_reset();
    out_ready[2] = 1'b0;
    @(negedge clk); put(0, 2'd1, 16'h0002);
    @(negedge clk); put(0, 2'd2, 16'h1111);
    @(negedge clk); put(0, 2'd2, 16'h2222);
    chk("R1 fill head ack", 32'(ack_i[0]), 32'h1);
    @(negedge clk); put(0, 2'd2, 16'h3333);
    chk("R2 fill body1 ack", 32'(ack_i[0]), 32'h1);
    @(negedge clk); put(0, 2'd2, 16'h4444);
    chk("R2 fill body2 ack", 32'(ack_i[0]), 32'h1);
    @(negedge clk); put(0, 2'd2, 16'h5555);
    chk("R2 fill body3 ack", 32'(ack_i[0]), 32'h1);
    @(negedge clk); idle_all();
    chk("R4 full queue nack", 32'(nack_i[0]), 32'h1);
    chk("R10 stalled head kept", 32'(okind_i[2*2 +: 2]), 32'h1);
    @(negedge clk);
    chk("R5 after full drop nack", 32'(nack_i[0]), 32'h1);
    chk("R10 stalled head data", 32'(odata_i[DW*2 +: DW]), 32'h0000);
    out_ready[2] = 1'b1;
    @(negedge clk);
    chk("R10 order 1", 32'(odata_i[DW*2 +: DW]), 32'h1111);
    @(negedge clk);
    chk("R10 order 2", 32'(odata_i[DW*2 +: DW]), 32'h2222);
    @(negedge clk);
    chk("R10 order 3", 32'(odata_i[DW*2 +: DW]), 32'h3333);
    @(negedge clk);
    chk("R4 dropped flit not queued", 32'(okind_i[2*2 +: 2]), 32'h0);

    // arbitration: fixed priority and round robin
    do_reset();
    @(negedge clk); put(0, 2'd1, 16'h1000); put(1, 2'd1, 16'h2000); put(2, 2'd1, 16'h3000);
    @(negedge clk); idle_all();
    @(negedge clk);
    chk("R6 rr round1 ack", 32'(ack_i), 32'h1);
    chk("R6 rr round1 nack", 32'(nack_i), 32'h6);
    chk("R6 fixed round1 ack", 32'(ack_f), 32'h1);
    chk("R6 round1 winner data", 32'(odata_i[DW*0 +: DW]), 32'h1000);
    put(0, 2'd3, 16'h0000);
    @(negedge clk); idle_all();
    @(negedge clk);
    chk("R2 round1 tail ack", 32'(ack_i[0]), 32'h1);
    put(0, 2'd1, 16'h1000); put(1, 2'd1, 16'h2000); put(2, 2'd1, 16'h3000);
    @(negedge clk); idle_all();
    @(negedge clk);
    chk("R7 rr round2 winner", 32'(ack_i), 32'h2);
    chk("R6 fixed round2 winner", 32'(ack_f), 32'h1);
    chk("R7 rr round2 data", 32'(odata_i[DW*0 +: DW]), 32'h2000);
    put(0, 2'd3, 16'h0000); put(1, 2'd3, 16'h0000);
    @(negedge clk); idle_all();
    @(negedge clk);
    chk("R5 rr pathless tail", 32'({ack_i, nack_i}), 32'({3'b010, 3'b001}));
    chk("R5 fixed pathless tail", 32'({ack_f, nack_f}), 32'({3'b001, 3'b010}));
    @(negedge clk);
    put(1, 2'd1, 16'h2000); put(2, 2'd1, 16'h3000);
    @(negedge clk); idle_all();
    @(negedge clk);
    chk("R7 rr start kept over idle", 32'(ack_i), 32'h4);
    chk("R6 fixed lowest wins", 32'(ack_f), 32'h2);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule